// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command strobes of a four-bank double-data-rate SDRAM, either as a passive monitor on the memory bus or as the front end of a device model. On every rising clock it turns clock enable, chip select and the three row/column/write strobes into one command. It keeps the state of each bank: closed, open, or in its row-close recovery. It reports commands that break the rules of that state machine. Read and write data, refresh, mode setup and read latency are outside its job.

Each bank has its own recovery counter. A single burst tracker follows the most recent accepted read or write. When a row close is issued to the bank of a running burst, the tracker ends that burst. When a burst carries the self-close flag, the tracker closes its bank once the burst has run its full length. All outputs are registered. They show the result for the command sampled at the previous rising edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_o` shows the command sampled at the previous rising edge. It is 0 (deselect) when `cke` is low or `cs_n` is high. Otherwise {ras_n,cas_n,we_n} selects the code: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 4 (write) and 010 gives 5 (precharge). The three remaining patterns give 6 (other).
- R2: `bank_o` loads `ba` on an activate, read, write or precharge. `col_o` loads `addr` with bit 10 forced to zero on every read or write. Both keep their value on all other commands.
- R3: Bank b's state is `bank_state_o[2b+1:2b]`, coded 0 idle, 1 open, 2 closing. An activate to an idle bank makes it open.
- R4: A precharge with `addr[10]` low moves only bank `ba` from open to closing. Other banks keep their state, and an idle bank stays idle.
- R5: A precharge with `addr[10]` high moves every open bank to closing, whatever the value of `ba`.
- R6: A bank stays closing for TRP clocks after the precharge edge and then goes idle. An activate sampled fewer than TRP edges after the precharge pulses `err_o` and leaves the state unchanged. An activate sampled at TRP edges or later is accepted.
- R7: An activate to an open bank pulses `err_o` and leaves the bank open.
- R8: A read or write to a bank that is not open pulses `err_o` and starts no burst.
- R9: An accepted read or write starts a burst that is running for the next BURST_LEN edges. A precharge sampled 1 to BURST_LEN edges later pulses `abort_o` if it covers the burst's bank, either by an `ba` match or by `addr[10]` high. A precharge that does not cover that bank does not pulse `abort_o`.
- R10: An accepted read or write with `addr[10]` high pulses `autopre_o` exactly BURST_LEN edges later, and its bank becomes closing at that edge. If a covering precharge is sampled at that edge, `abort_o` pulses in place of `autopre_o`.
- R11: A read or write sampled while a self-closing burst is running pulses `err_o` and is ignored. The running burst keeps its timing.
- R12: A read or write accepted during a burst without the self-close flag restarts the burst window from its own edge.
- R13: Deselect, no-op and the other commands change no bank state and raise no error. This includes activate strobes sampled with `cke` low.
- R14: A synchronous active-high `rst` sets all banks idle and clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low forces deselect |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address bus; bit 10 is the close-all or self-close flag |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank of the last bank-addressed command |
| col_o | output | 12 | Start column of the last read or write |
| bank_state_o | output | 8 | Two state bits per bank |
| err_o | output | 1 | Rule-violation pulse |
| abort_o | output | 1 | Burst-terminated pulse |
| autopre_o | output | 1 | Self-close event pulse |

## Verification
There are two collisions to provoke. In the first, a self-closing burst reaches its last edge in the same cycle that an explicit precharge is sampled for the same bank. The bench puts the precharge exactly BURST_LEN edges after the read. It expects `abort_o` high, `autopre_o` low and the bank closing. In the second, a read and an activate land on the last edge of a self-closing burst, or on the last edge of a bank's recovery. Here the bench sweeps the command gap across each window boundary. Each expected error, abort or state is worked out from TRP and BURST_LEN.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_OTHER = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;

  // strobe pins to command code
  function automatic cmd_e pins_to_cmd(input logic cke, input logic cs_n,
                                       input logic ras_n, input logic cas_n,
                                       input logic we_n);
    cmd_e c;
    if (!cke || cs_n) begin
      c = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction

  // a row-close command covers a bank when it is close-all or names it
  function automatic logic close_covers(input logic all_banks, input logic match);
    return all_banks || match;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd,
  output logic              is_act,
  output logic              is_rd,
  output logic              is_wr,
  output logic              is_pre,
  output logic              flag10,
  output logic [ADDR_W-1:0] col
);

  always_comb begin
    cmd         = pins_to_cmd(cke, cs_n, ras_n, cas_n, we_n);
    is_act      = (cmd == CMD_ACT);
    is_rd       = (cmd == CMD_RD);
    is_wr       = (cmd == CMD_WR);
    is_pre      = (cmd == CMD_PRE);
    flag10      = addr[AP_BIT];
    col         = addr;
    col[AP_BIT] = 1'b0;
  end

endmodule

// File: rtl/sdcmd_bank.sv
`timescale 1ns/1ps
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int TRP = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     act_sel,
  input  logic     pre_hit,
  input  logic     ap_close,
  output bank_st_e state,
  output logic     act_bad
);

  localparam int CW = (TRP > 1) ? $clog2(TRP) : 1;
  localparam logic [CW-1:0] LOAD = CW'(TRP - 1);

  logic [CW-1:0] cnt;
  logic          ready;
  logic          act_go;
  logic          close_go;

  assign ready    = (state == BK_IDLE) || (state == BK_CLOSING && cnt == '0);
  assign act_go   = act_sel && ready;
  assign act_bad  = act_sel && !ready;
  assign close_go = close_covers(pre_hit, ap_close) && (state == BK_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        BK_IDLE: begin
          if (act_go) state <= BK_OPEN;
        end
        BK_OPEN: begin
          if (close_go) begin
            state <= BK_CLOSING;
            cnt   <= LOAD;
          end
        end
        BK_CLOSING: begin
          if (act_go)          state <= BK_OPEN;
          else if (cnt == '0)  state <= BK_IDLE;
          else                 cnt   <= cnt - 1'b1;
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  AST_OPEN_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
    (state == BK_OPEN && $past(state) != BK_OPEN) |-> $past(act_sel)); // R3

  AST_CLOSE_FROM_OPEN: assert property (@(posedge clk) disable iff (rst)
    (state == BK_CLOSING && $past(state) != BK_CLOSING) |-> $past(state) == BK_OPEN); // R4

  AST_LOCKOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == BK_CLOSING) |-> (cnt <= LOAD)); // R6

  AST_LOCKOUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state == BK_CLOSING && cnt == '0 && !act_sel) |=> state == BK_IDLE); // R6

endmodule

// File: rtl/sdcmd_burst.sv
`timescale 1ns/1ps
module sdcmd_burst
  import sdcmd_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int BL   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic            pre_cmd,
  input  logic            pre_all,
  input  logic [BA_W-1:0] pre_bank,
  output logic            busy,
  output logic            ap_busy,
  output logic            kill,
  output logic            ap_fire,
  output logic [BA_W-1:0] cur_bank
);

  localparam int CW = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [CW-1:0] LOAD = CW'(BL - 1);

  logic [CW-1:0] left;
  logic          ap_r;

  assign ap_busy = busy && ap_r;
  assign kill    = busy && pre_cmd && close_covers(pre_all, pre_bank == cur_bank);
  assign ap_fire = ap_busy && (left == '0) && !kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ap_r     <= 1'b0;
      left     <= '0;
      cur_bank <= '0;
    end else if (kill) begin
      busy <= 1'b0;
      ap_r <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      ap_r     <= start_ap;
      left     <= LOAD;
      cur_bank <= start_bank;
    end else if (busy) begin
      if (left == '0) begin
        busy <= 1'b0;
        ap_r <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end

  AST_BURST_LEFT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left <= LOAD)); // R9

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kill |=> !busy); // R9

  AST_AP_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
    ap_fire |=> !busy); // R10

  AST_NO_START_OVER_AP: assert property (@(posedge clk) disable iff (rst)
    ap_busy |-> !start); // R11

endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [BA_W-1:0]          ba,
  input  logic [ADDR_W-1:0]        addr,
  output logic [2:0]               cmd_o,
  output logic [BA_W-1:0]          bank_o,
  output logic [ADDR_W-1:0]        col_o,
  output logic [2*(2**BA_W)-1:0]   bank_state_o,
  output logic                     err_o,
  output logic                     abort_o,
  output logic                     autopre_o
);

  localparam int NB = 2 ** BA_W;

  cmd_e              cmd;
  logic              is_act, is_rd, is_wr, is_pre, flag10;
  logic [ADDR_W-1:0] col;

  bank_st_e          st [NB];
  logic [NB-1:0]     act_bad;

  logic              busy, ap_busy, kill, ap_fire;
  logic [BA_W-1:0]   cur_bank;
  logic              rw, rw_start, rw_bad, err_next;

  sdcmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cmd(cmd), .is_act(is_act), .is_rd(is_rd), .is_wr(is_wr),
    .is_pre(is_pre), .flag10(flag10), .col(col)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic here;
    assign here = (ba == BA_W'(b));
    sdcmd_bank #(.TRP(TRP)) u_bank (
      .clk(clk), .rst(rst),
      .act_sel(is_act && here),
      .pre_hit(is_pre && close_covers(flag10, here)),
      .ap_close(ap_fire && cur_bank == BA_W'(b)),
      .state(st[b]),
      .act_bad(act_bad[b])
    );
    assign bank_state_o[2*b +: 2] = st[b];
  end

  assign rw       = is_rd || is_wr;
  assign rw_start = rw && (st[ba] == BK_OPEN) && !ap_busy;
  assign rw_bad   = rw && !rw_start;
  assign err_next = (|act_bad) || rw_bad;

  sdcmd_burst #(.BA_W(BA_W), .BL(BURST_LEN)) u_burst (
    .clk(clk), .rst(rst),
    .start(rw_start), .start_ap(flag10), .start_bank(ba),
    .pre_cmd(is_pre), .pre_all(flag10), .pre_bank(ba),
    .busy(busy), .ap_busy(ap_busy), .kill(kill), .ap_fire(ap_fire),
    .cur_bank(cur_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o     <= 3'd0;
      bank_o    <= '0;
      col_o     <= '0;
      err_o     <= 1'b0;
      abort_o   <= 1'b0;
      autopre_o <= 1'b0;
    end else begin
      cmd_o     <= cmd;
      if (is_act || rw || is_pre) bank_o <= ba;
      if (rw) col_o <= col;
      err_o     <= err_next;
      abort_o   <= kill;
      autopre_o <= ap_fire;
    end
  end

  AST_ERR_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cmd_o == 3'd2 || cmd_o == 3'd3 || cmd_o == 3'd4)); // R7

  AST_QUIET_CMDS: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd0 || cmd_o == 3'd1 || cmd_o == 3'd6) |-> !err_o); // R13

  AST_ABORT_IS_PRE: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> cmd_o == 3'd5); // R9

  AST_ABORT_AP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(abort_o && autopre_o)); // R10

  AST_ONE_ACT_BAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_bad)); // R7

  AST_RW_BAD_NO_BURST: assert property (@(posedge clk) disable iff (rst)
    (rw_bad && !busy) |=> !busy); // R8

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  localparam int TRP = 3;
  localparam int BL  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [11:0] addr = 12'd0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] col_o;
  logic [7:0]  bank_state_o;
  logic        err_o, abort_o, autopre_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_tracker #(.BA_W(2), .ADDR_W(12), .AP_BIT(10), .TRP(TRP), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
    .col_o(col_o), .bank_state_o(bank_state_o), .err_o(err_o),
    .abort_o(abort_o), .autopre_o(autopre_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] bst(input int b);
    return bank_state_o[2*b +: 2];
  endfunction

  // bench-side expected command code
  function automatic logic [2:0] exp_cmd(input logic k, input logic c, input logic r,
                                         input logic a, input logic w);
    if (k == 1'b0 || c == 1'b1) return 3'd0;
    if (r && a && w)   return 3'd1;
    if (!r && a && w)  return 3'd2;
    if (r && !a && w)  return 3'd3;
    if (r && !a && !w) return 3'd4;
    if (!r && a && !w) return 3'd5;
    return 3'd6;
  endfunction

  // 0 desel 1 nop 2 act 3 rd 4 wr 5 pre 6 other
  task automatic send(input int c, input int b, input logic [11:0] a);
    cke = 1'b1;
    cs_n = 1'b0;
    case (c)
      0: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
      1: {ras_n, cas_n, we_n} = 3'b111;
      2: {ras_n, cas_n, we_n} = 3'b011;
      3: {ras_n, cas_n, we_n} = 3'b101;
      4: {ras_n, cas_n, we_n} = 3'b100;
      5: {ras_n, cas_n, we_n} = 3'b010;
      default: {ras_n, cas_n, we_n} = 3'b001;
    endcase
    ba = 2'(b);
    addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(1, 0, 12'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cs_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R14 reset state
    chk("R14 cmd", cmd_o, 0);
    chk("R14 states", bank_state_o, 0);
    chk("R14 pulses", {err_o, abort_o, autopre_o}, 0);
    chk("R14 col", col_o, 0);

    // R1 exhaustive pin sweep
    for (int v = 0; v < 32; v++) begin
      {cke, cs_n, ras_n, cas_n, we_n} = 5'(v);
      ba = 2'd0;
      addr = 12'h0;
      @(posedge clk);
      #1;
      chk($sformatf("R1 code v=%0d", v), cmd_o, exp_cmd(v[4], v[3], v[2], v[1], v[0]));
    end

    // R13 quiet commands, R3 activate
    do_reset();
    send(2, 1, 12'h0);
    chk("R3 open bank1", bst(1), 1);
    cke = 1'b0; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b011; ba = 2'd2;
    @(posedge clk); #1;
    chk("R13 cke low act", {bank_state_o, err_o}, {8'h04, 1'b0});
    send(0, 3, 12'h0);
    send(1, 3, 12'h0);
    send(6, 3, 12'h0);
    chk("R13 quiet states", {bank_state_o, err_o}, {8'h04, 1'b0});

    // R2 capture
    do_reset();
    send(2, 2, 12'h0);
    chk("R2 bank act", bank_o, 2);
    send(3, 2, 12'h9A5);
    chk("R2 col rd", col_o, 12'h9A5);
    send(1, 1, 12'h123);
    chk("R2 hold", {bank_o, col_o}, {2'd2, 12'h9A5});
    nops(BL);
    send(4, 2, 12'hFFF);
    chk("R2 col strip10", col_o, 12'hBFF);

    // R3 / R7 per bank
    do_reset();
    for (int b = 0; b < 4; b++) begin
      send(2, b, 12'h0);
      chk($sformatf("R3 open b%0d", b), {bst(b), err_o}, {2'd1, 1'b0});
      send(2, b, 12'h0);
      chk($sformatf("R7 reopen b%0d", b), {bst(b), err_o}, {2'd1, 1'b1});
    end

    // R4 single-bank close sweep
    for (int a = 0; a < 4; a++) begin
      do_reset();
      for (int b = 0; b < 4; b++) send(2, b, 12'h0);
      send(5, a, 12'h0);
      for (int b = 0; b < 4; b++)
        chk($sformatf("R4 pre%0d b%0d", a, b), bst(b), (b == a) ? 2 : 1);
    end
    do_reset();
    send(5, 0, 12'h0);
    chk("R4 idle stays", {bank_state_o, err_o}, 0);

    // R5 close all
    do_reset();
    send(2, 0, 12'h0);
    send(2, 2, 12'h0);
    send(5, 1, 12'h400);
    chk("R5 all", bank_state_o, 8'b00_10_00_10);

    // R6 lockout length
    do_reset();
    send(2, 0, 12'h0);
    send(5, 0, 12'h0);
    chk("R6 closing", bst(0), 2);
    for (int i = 1; i <= TRP; i++) begin
      send(1, 0, 12'h0);
      chk($sformatf("R6 after %0d", i), bst(0), (i < TRP) ? 2 : 0);
    end
    // R6 activate gap sweep
    for (int j = 1; j <= TRP + 1; j++) begin
      do_reset();
      send(2, 0, 12'h0);
      send(5, 0, 12'h0);
      nops(j - 1);
      send(2, 0, 12'h0);
      chk($sformatf("R6 gap %0d", j), {bst(0), err_o},
          (j < TRP) ? {2'd2, 1'b1} : {2'd1, 1'b0});
    end

    // R8 access to closed bank
    do_reset();
    send(3, 3, 12'h0);
    chk("R8 rd idle", err_o, 1);
    send(2, 3, 12'h0);
    send(5, 3, 12'h0);
    chk("R8 no burst", abort_o, 0);
    send(4, 1, 12'h0);
    chk("R8 wr idle", err_o, 1);

    // R9 abort gap sweep
    for (int j = 1; j <= BL + 1; j++) begin
      do_reset();
      send(2, 1, 12'h0);
      send(3, 1, 12'h0);
      nops(j - 1);
      send(5, 1, 12'h0);
      chk($sformatf("R9 gap %0d", j), abort_o, (j <= BL) ? 1 : 0);
    end
    do_reset();
    send(2, 0, 12'h0);
    send(2, 1, 12'h0);
    send(4, 1, 12'h0);
    send(5, 0, 12'h0);
    chk("R9 other bank", abort_o, 0);
    send(5, 2, 12'h400);
    chk("R9 all covers", abort_o, 1);

    // R10 self-close timing
    do_reset();
    send(2, 2, 12'h0);
    send(3, 2, 12'h400);
    for (int i = 1; i <= BL + 1; i++) begin
      send(1, 0, 12'h0);
      chk($sformatf("R10 beat %0d", i), {autopre_o, bst(2)},
          {(i == BL) ? 1'b1 : 1'b0, (i < BL) ? 2'd1 : 2'd2});
    end
    // R10 collision with explicit precharge
    do_reset();
    send(2, 2, 12'h0);
    send(4, 2, 12'h400);
    nops(BL - 1);
    send(5, 2, 12'h0);
    chk("R10 collide", {abort_o, autopre_o, bst(2)}, {1'b1, 1'b0, 2'd2});

    // R11 access during self-close burst
    do_reset();
    send(2, 0, 12'h0);
    send(2, 1, 12'h0);
    send(3, 0, 12'h400);
    send(4, 1, 12'h0);
    chk("R11 rejected", err_o, 1);
    nops(BL - 2);
    send(3, 1, 12'h0);
    chk("R11 last edge", {err_o, autopre_o, bst(0), bst(1)}, {1'b1, 1'b1, 2'd2, 2'd1});

    // R12 restart
    do_reset();
    send(2, 0, 12'h0);
    send(3, 0, 12'h0);
    send(1, 0, 12'h0);
    send(3, 0, 12'h0);
    nops(BL - 1);
    send(5, 0, 12'h0);
    chk("R12 restart", abort_o, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule